// File: doc/BRIEF.md
# Loop-Only Program Sequencer

This block steps a signal-processing program that has no branches. A program counter addresses an external instruction store of 192 words of 24 bits. The counter moves up by one address each cycle and returns to address 0 after the last word, so the program repeats for as long as the clock runs. Every instruction takes exactly one cycle. A program shorter than the store ends with an end-of-program word. That word may only sit at an address that is a multiple of four. The three addresses after it are still fetched, but they are always squashed into no-ops, and the fetch after the third one returns to address 0.

Any instruction can be predicated on one bit of the converter register. A control field in the word picks the bit and the value it must hold. When the bit does not match, the instruction is issued as a no-op. An end-of-program word placed at a misaligned address does not restart the loop. It is issued as a no-op and raises an alignment error flag for that issue cycle.

The store gives its word in the same cycle as the address. The block registers the word, its address and an execute-enable, and presents them to the datapath one cycle after the fetch.

Top module: `loopseq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block sets `fetch_addr` to 0 and clears `issue_addr`, `issue_instr`, `issue_exec` and `align_err`. Any pending restart is forgotten.
- R2: After reset, `fetch_addr` goes up by one each cycle. The word fetched in a cycle appears on `issue_instr` one cycle later, with its address on `issue_addr`.
- R3: When `fetch_addr` is 191 and no restart is due, the next fetch is address 0.
- R4: The word layout is: bit 23 is the condition enable, bit 22 is the required bit value, bits 21:18 select the condition bit, and bits 17:12 hold the opcode. Opcode 0x00 is a no-op and is issued with `issue_exec` low. Any other opcode except 0x3F is issued with `issue_exec` high when its condition holds.
- R5: When bit 23 is set, the instruction executes only if `cond_reg[sel]` equals bit 22. Otherwise it is issued with `issue_exec` low. A select of 9 or more reads as 0.
- R6: Opcode 0x3F is end-of-program. At an address that is a multiple of 4, with its condition holding, it is issued with `issue_exec` low. The next three addresses are fetched and issued with `issue_exec` low whatever they hold. The fetch after them is address 0.
- R7: An end-of-program word at an address that is not a multiple of 4 is issued with `issue_exec` low and `align_err` high. Fetching continues at the next address.
- R8: An end-of-program word whose condition fails is issued as a plain no-op. It causes no restart and no alignment error.
- R9: Words fetched in the three slots after an end-of-program word are ignored. This includes a further end-of-program word: it causes neither a new restart nor an alignment error.
- R10: A reset applied during the three slots cancels the pending restart. Fetching then resumes from 0 without any early return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cond_reg | input | 9 | Converter register bits that conditional words test |
| fetch_addr | output | 8 | Address presented to the instruction store |
| fetch_data | input | 24 | Word read from the store at `fetch_addr`, same cycle |
| issue_instr | output | 24 | Registered instruction word for the datapath |
| issue_addr | output | 8 | Address the issued word came from |
| issue_exec | output | 1 | High when the issued word must take effect |
| align_err | output | 1 | High for the issue cycle of a misaligned end-of-program word |

## Verification
The hardest case to reach is a reset that lands while restart slots are still pending. The bench places an end-of-program word at address 8 and counts cycles from reset until the word at address 9 has been issued, so the counter is inside its slots. It then pulses reset and follows the fetch order well past address 11. A leftover pending restart would show up as an early return to address 0. A second hard case is an end-of-program word that falls inside the slots. The bench builds a four-word loop whose second word is a misaligned end-of-program word, so that word would raise an error if it were not squashed.

// File: rtl/loopseq_pkg.sv
// Package: field positions and opcodes of the sequencer instruction word.
// Assumes a fixed 24-bit word; only the control fields are decoded here.
package loopseq_pkg;
    localparam int unsigned WORD_W   = 24;
    localparam int unsigned F_CEN    = 23;
    localparam int unsigned F_POL    = 22;
    localparam int unsigned F_SEL_HI = 21;
    localparam int unsigned F_SEL_LO = 18;
    localparam int unsigned F_OP_HI  = 17;
    localparam int unsigned F_OP_LO  = 12;
    localparam int unsigned SEL_W    = F_SEL_HI - F_SEL_LO + 1;
    localparam int unsigned OP_W     = F_OP_HI - F_OP_LO + 1;

    localparam logic [OP_W-1:0] OP_NOP = 6'h00;
    localparam logic [OP_W-1:0] OP_EOP = 6'h3F;

    typedef struct packed {
        logic             cen;
        logic             pol;
        logic [SEL_W-1:0] sel;
        logic [OP_W-1:0]  op;
    } ctl_t;

    // Pull the control fields out of a raw word.
    function automatic ctl_t split_word(input logic [WORD_W-1:0] w);
        ctl_t c;
        c.cen = w[F_CEN];
        c.pol = w[F_POL];
        c.sel = w[F_SEL_HI:F_SEL_LO];
        c.op  = w[F_OP_HI:F_OP_LO];
        return c;
    endfunction
endpackage

// File: rtl/loopseq_decode.sv
// Module: loopseq_decode
// Decodes the word being fetched. It evaluates the predicate against the
// converter register and classifies the word as: executable, aligned restart,
// misaligned end-of-program, or squashed.
// Assumes the word and its address belong to the same cycle. A select beyond
// the register width reads as 0.
module loopseq_decode
    import loopseq_pkg::*;
#(
    parameter int unsigned AW    = 8,
    parameter int unsigned CW    = 9,
    parameter int unsigned ALIGN = 4
) (
    input  logic [WORD_W-1:0] word,
    input  logic [AW-1:0]     addr,
    input  logic [CW-1:0]     cond_reg,
    input  logic              in_slot,
    output logic              exec,
    output logic              restart,
    output logic              misalign
);
    ctl_t ctl;
    logic cond_bit;
    logic cond_ok;
    logic aligned;

    assign ctl     = split_word(word);
    assign aligned = ((32'(addr) % ALIGN) == 0);

    // Pick the selected converter bit, or 0 if the select is out of range.
    always_comb begin
        cond_bit = 1'b0;
        for (int i = 0; i < int'(CW); i++) begin
            if (ctl.sel == SEL_W'(i)) cond_bit = cond_reg[i];
        end
    end

    assign cond_ok = !ctl.cen || (cond_bit == ctl.pol);

    // Classify the word; slots and failed predicates squash everything.
    always_comb begin
        exec     = 1'b0;
        restart  = 1'b0;
        misalign = 1'b0;
        if (!in_slot && cond_ok) begin
            if (ctl.op == OP_EOP) begin
                restart  = aligned;
                misalign = !aligned;
            end else begin
                exec = (ctl.op != OP_NOP);
            end
        end
    end
endmodule

// File: rtl/loopseq_pc.sv
// Module: loopseq_pc
// Program counter with wrap-around and a restart slot counter. A restart
// request starts a countdown of SLOTS fetches; after the last slot the PC
// returns to 0. With SLOTS = 0 the restart takes effect at the next fetch.
// Assumes restart is never requested while a countdown is running.
module loopseq_pc #(
    parameter int unsigned DEPTH = 192,
    parameter int unsigned SLOTS = 3,
    parameter int unsigned AW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [AW-1:0] pc,
    output logic          in_slot
);
    localparam int unsigned SW = (SLOTS > 0) ? $clog2(SLOTS + 1) : 1;

    logic [AW-1:0] pc_q, pc_d, pc_inc;
    logic [SW-1:0] slot_q, slot_d;

    assign pc_inc  = (pc_q == AW'(DEPTH - 1)) ? '0 : pc_q + 1'b1;
    assign pc      = pc_q;
    assign in_slot = (slot_q != '0);

    // Choose the next fetch address and the slot count.
    always_comb begin
        pc_d   = pc_inc;
        slot_d = slot_q;
        if (slot_q != '0) begin
            slot_d = slot_q - 1'b1;
            if (slot_q == SW'(1)) pc_d = '0;
        end else if (restart) begin
            if (SLOTS == 0) pc_d = '0;
            else            slot_d = SW'(SLOTS);
        end
    end

    // Hold the PC and slot count; reset clears both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            slot_q <= '0;
        end else begin
            pc_q   <= pc_d;
            slot_q <= slot_d;
        end
    end
endmodule

// File: rtl/loopseq_issue.sv
// Module: loopseq_issue
// Issue register: presents each fetched word, its address and its flags to
// the datapath one cycle after the fetch.
// Assumes the inputs are settled before the clock edge.
module loopseq_issue
    import loopseq_pkg::*;
#(
    parameter int unsigned AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_in,
    input  logic [AW-1:0]     addr_in,
    input  logic              exec_in,
    input  logic              err_in,
    output logic [WORD_W-1:0] word_out,
    output logic [AW-1:0]     addr_out,
    output logic              exec_out,
    output logic              err_out
);
    // Capture the fetch-stage result; reset clears it to an idle issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out <= '0;
            addr_out <= '0;
            exec_out <= 1'b0;
            err_out  <= 1'b0;
        end else begin
            word_out <= word_in;
            addr_out <= addr_in;
            exec_out <= exec_in;
            err_out  <= err_in;
        end
    end
endmodule

// File: rtl/loopseq.sv
// Module: loopseq (top)
// Branch-free program sequencer. It fetches words from an external store in
// address order, wraps at DEPTH, and restarts early after an aligned
// end-of-program word plus SLOTS squashed slots. It predicates each word on
// a converter register bit.
// Assumes the store returns fetch_data in the same cycle as fetch_addr.
module loopseq
    import loopseq_pkg::*;
#(
    parameter int unsigned DEPTH = 192,
    parameter int unsigned CW    = 9,
    parameter int unsigned SLOTS = 3,
    parameter int unsigned ALIGN = 4,
    parameter int unsigned AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     cond_reg,
    output logic [AW-1:0]     fetch_addr,
    input  logic [WORD_W-1:0] fetch_data,
    output logic [WORD_W-1:0] issue_instr,
    output logic [AW-1:0]     issue_addr,
    output logic              issue_exec,
    output logic              align_err
);
    logic [AW-1:0] pc;
    logic          in_slot;
    logic          dec_exec;
    logic          dec_restart;
    logic          dec_misalign;

    loopseq_pc #(.DEPTH(DEPTH), .SLOTS(SLOTS), .AW(AW)) u_pc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (dec_restart),
        .pc      (pc),
        .in_slot (in_slot)
    );

    loopseq_decode #(.AW(AW), .CW(CW), .ALIGN(ALIGN)) u_dec (
        .word     (fetch_data),
        .addr     (pc),
        .cond_reg (cond_reg),
        .in_slot  (in_slot),
        .exec     (dec_exec),
        .restart  (dec_restart),
        .misalign (dec_misalign)
    );

    loopseq_issue #(.AW(AW)) u_iss (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_in  (fetch_data),
        .addr_in  (pc),
        .exec_in  (dec_exec),
        .err_in   (dec_misalign),
        .word_out (issue_instr),
        .addr_out (issue_addr),
        .exec_out (issue_exec),
        .err_out  (align_err)
    );

    assign fetch_addr = pc;
endmodule

// File: rtl/loopseq_chk.sv
// Module: loopseq_chk
// Port-level checker bound to loopseq. It checks address order, wrap, the
// issue delay and the flags of no-op and end-of-program words.
module loopseq_chk
    import loopseq_pkg::*;
#(
    parameter int unsigned DEPTH = 192,
    parameter int unsigned AW    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [AW-1:0]     fetch_addr,
    input logic [WORD_W-1:0] issue_instr,
    input logic [AW-1:0]     issue_addr,
    input logic              issue_exec,
    input logic              align_err
);
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (fetch_addr == '0) && !issue_exec && !align_err); // R1
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && fetch_addr != '0) |-> fetch_addr == AW'($past(fetch_addr) + 1'b1)); // R2
    AST_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fetch_addr) == AW'(DEPTH - 1)) |-> fetch_addr == '0); // R3
    AST_ISSUE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> issue_addr == $past(fetch_addr)); // R2
    AST_NOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_instr[F_OP_HI:F_OP_LO] == OP_NOP) |-> !issue_exec); // R4
    AST_EOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_instr[F_OP_HI:F_OP_LO] == OP_EOP) |-> !issue_exec); // R6
    AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> (issue_instr[F_OP_HI:F_OP_LO] == OP_EOP) && (issue_addr[1:0] != 2'b00)); // R7
    AST_ERR_NO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> !issue_exec); // R7
endmodule

bind loopseq loopseq_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_addr  (fetch_addr),
    .issue_instr (issue_instr),
    .issue_addr  (issue_addr),
    .issue_exec  (issue_exec),
    .align_err   (align_err)
);

// File: tb/loopseq_bench.sv
// Directed bench for loopseq: one task per scenario, each checking itself.
module loopseq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  cond_reg = '0;
    logic [7:0]  fetch_addr;
    logic [23:0] fetch_data;
    logic [23:0] issue_instr;
    logic [7:0]  issue_addr;
    logic        issue_exec;
    logic        align_err;

    logic [23:0] mem [192];
    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    assign fetch_data = (fetch_addr < 8'd192) ? mem[fetch_addr] : 24'h0;

    loopseq u_loopseq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cond_reg    (cond_reg),
        .fetch_addr  (fetch_addr),
        .fetch_data  (fetch_data),
        .issue_instr (issue_instr),
        .issue_addr  (issue_addr),
        .issue_exec  (issue_exec),
        .align_err   (align_err)
    );

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual=%0d expected<=100000", cycles);
            finish_run();
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Plain executable word: opcode 0x01, operand = address.
    task automatic fill_plain();
        for (int i = 0; i < 192; i++) mem[i] = {6'b0, 6'h01, 12'(i)};
    endtask

    function automatic logic [23:0] mk(input bit cen, input bit pol,
                                       input int sel, input logic [5:0] op);
        return {cen, pol, 4'(sel), op, 12'h0A5};
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    // Advance one cycle and check the issued address, exec and error.
    task automatic expect_issue(input string req, input int a, input bit ex, input bit er);
        tick();
        chk({req, " addr"}, issue_addr, a);
        chk({req, " exec"}, issue_exec, ex);
        chk({req, " err"}, align_err, er);
    endtask

    task automatic t_reset();
        fill_plain();
        rst_n = 1'b0;
        tick();
        tick();
        chk("R1 fetch", fetch_addr, 0);
        chk("R1 addr", issue_addr, 0);
        chk("R1 exec", issue_exec, 0);
        chk("R1 err", align_err, 0);
        chk("R1 instr", issue_instr, 0);
    endtask

    task automatic t_wrap();
        fill_plain();
        do_reset();
        for (int k = 0; k < 196; k++) begin
            tick();
            chk("R2 addr", issue_addr, k % 192);
            chk("R2 instr", issue_instr, mem[k % 192]);
            chk("R2 exec", issue_exec, 1);
            chk("R3 fetch", fetch_addr, (k + 1) % 192);
        end
    endtask

    task automatic t_nop();
        fill_plain();
        mem[5] = mk(0, 0, 0, 6'h00);
        do_reset();
        for (int k = 0; k < 8; k++) expect_issue("R4 nop", k, k != 5, 0);
    endtask

    task automatic t_cond();
        fill_plain();
        mem[2] = mk(1, 1, 3, 6'h02);
        mem[3] = mk(1, 0, 3, 6'h02);
        mem[4] = mk(1, 1, 12, 6'h02);
        mem[5] = mk(1, 0, 12, 6'h02);
        cond_reg = 9'b000001000;
        do_reset();
        for (int k = 0; k < 7; k++) expect_issue("R5 set", k, !(k == 3 || k == 4), 0);
        cond_reg = 9'b111110111;
        do_reset();
        for (int k = 0; k < 7; k++) expect_issue("R5 clr", k, !(k == 2 || k == 4), 0);
        cond_reg = '0;
    endtask

    task automatic t_eop_aligned();
        fill_plain();
        mem[8] = mk(0, 0, 0, 6'h3F);
        do_reset();
        for (int k = 0; k < 24; k++) expect_issue("R6 loop", k % 12, (k % 12) < 8, 0);
    endtask

    task automatic t_eop_misaligned();
        fill_plain();
        mem[6]  = mk(0, 0, 0, 6'h3F);
        mem[12] = mk(0, 0, 0, 6'h3F);
        do_reset();
        for (int k = 0; k < 17; k++) begin
            int a = k % 16;
            expect_issue("R7 mis", a, !(a == 6 || a >= 12), a == 6);
        end
    endtask

    task automatic t_eop_cond();
        fill_plain();
        mem[4] = mk(1, 1, 0, 6'h3F);
        cond_reg = 9'b0;
        do_reset();
        for (int k = 0; k < 10; k++) expect_issue("R8 fail", k, k != 4, 0);
        cond_reg = 9'b1;
        do_reset();
        for (int k = 0; k < 16; k++) expect_issue("R8 pass", k % 8, (k % 8) < 4, 0);
        cond_reg = '0;
    endtask

    task automatic t_slot_eop();
        fill_plain();
        mem[0] = mk(0, 0, 0, 6'h3F);
        mem[1] = mk(0, 0, 0, 6'h3F);
        do_reset();
        for (int k = 0; k < 12; k++) expect_issue("R9 slot", k % 4, 0, 0);
    endtask

    task automatic t_reset_slot();
        fill_plain();
        mem[8] = mk(0, 0, 0, 6'h3F);
        do_reset();
        for (int k = 0; k < 10; k++) expect_issue("R10 pre", k, k < 8, 0);
        chk("R10 in slot", fetch_addr, 10);
        rst_n = 1'b0;
        tick();
        chk("R10 fetch", fetch_addr, 0);
        chk("R10 exec", issue_exec, 0);
        rst_n = 1'b1;
        for (int k = 0; k < 13; k++) expect_issue("R10 post", k % 12, (k % 12) < 8, 0);
    endtask

    initial begin
        fill_plain();
        t_reset();
        t_wrap();
        t_nop();
        t_cond();
        t_eop_aligned();
        t_eop_misaligned();
        t_eop_cond();
        t_slot_eop();
        t_reset_slot();
        finish_run();
    end
endmodule